// File: doc/BRIEF.md
# Program Memory Byte Reader with Auto-Stepping Pointer

This block lets a processor core fetch constants and strings out of program memory one byte at a time. It keeps a 22-bit byte-address pointer that software loads one byte lane at a time. A read request returns the addressed byte in an 8-bit result latch, which software then copies into its working register. Program memory is organised as 16-bit words. The block sends the word address to memory and picks the wanted half of the returned word itself. Because the pointer is one bit wider than the core's program counter, it also reaches the configuration and identification areas that lie above normal code space.

Each read carries a 2-bit mode that says how the pointer moves. It can stay where it is, step up after the fetch, step down after the fetch, or step up before the fetch. A zero-terminated string is therefore walked by repeating post-increment reads until the latch reads zero. Every read takes exactly two cycles. In the first cycle the request is accepted. In the second cycle memory is accessed and `busy` is high. The latch updates at the end of the second cycle.

Top module: `tblptr_reader`

## Requirements
- R1: After reset the pointer is 0, the latch is 0, `busy` and `mem_rd` are low and `mem_addr` is 0.
- R2: While idle and with no read requested, `ptr_wr_en[0]` loads pointer bits 7:0, `ptr_wr_en[1]` loads bits 15:8 and `ptr_wr_en[2]` loads bits 21:16 from `ptr_wr_data[5:0]`. The pointer is shown on `ptr_rd` bits 21:0, and `ptr_rd` bits 23:22 always read 0.
- R3: A request seen with `busy` low makes `busy` and `mem_rd` high for exactly the next cycle and low again in the cycle after.
- R4: During the busy cycle `mem_addr` equals bits 21:1 of the access address. At the end of that cycle the latch takes `mem_rdata[7:0]` when access address bit 0 is 0, and `mem_rdata[15:8]` when it is 1.
- R5: Mode 2'b00 (hold) reads at the current pointer and leaves the pointer unchanged.
- R6: Mode 2'b01 (post-increment) and mode 2'b10 (post-decrement) read at the old pointer. The pointer shows old+1 or old-1 in the busy cycle.
- R7: Mode 2'b11 (pre-increment) reads at old+1 and leaves the pointer at old+1.
- R8: Pointer arithmetic wraps modulo 2^22: 0x3FFFFF plus one gives 0, and 0 minus one gives 0x3FFFFF. Carries and borrows cross all byte lanes.
- R9: A request raised while `busy` is high is ignored. A pointer write in the busy cycle, or in the same cycle as an accepted request, is ignored.
- R10: The latch keeps its value at all times other than the end of a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Byte read request |
| rd_mode | input | 2 | Pointer step mode for this read |
| ptr_wr_en | input | 3 | Per-lane pointer write enables (low, high, upper) |
| ptr_wr_data | input | 8 | Byte written to the enabled lanes |
| ptr_rd | output | 24 | Current pointer, zero-padded to three bytes |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 21 | Program memory word address |
| mem_rdata | input | 16 | Word returned by program memory during `mem_rd` |
| busy | output | 1 | Access in progress |
| tab_latch | output | 8 | Last byte read |

## Verification
A wrong pointer shows at the ports no later than the busy cycle that follows an accepted request: `mem_addr` carries the access address and `ptr_rd` already carries the stepped value, so either value is off. A wrong half-word choice, or a lost capture, shows on `tab_latch` in the first idle cycle after `busy` falls. Carry and borrow errors appear only at byte-lane and word edges. For that reason the sweep walks single set bits across all 22 positions in every mode and checks both wrap points. It also walks a zero-terminated string, so that a step taken twice or not at all shows up as a wrong character or a wrong stopping address.

// File: rtl/tblptr_pkg.sv
package tblptr_pkg;

  typedef enum logic [1:0] {
    TRD_HOLD     = 2'b00,
    TRD_POST_INC = 2'b01,
    TRD_POST_DEC = 2'b10,
    TRD_PRE_INC  = 2'b11
  } trd_mode_e;

endpackage

// File: rtl/tblptr_ptr_reg.sv
module tblptr_ptr_reg
  import tblptr_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int BYTE_W = 8,
  localparam int LANES = (PTR_W + BYTE_W - 1) / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_accept,
  input  logic              step_en,
  input  logic [1:0]        mode,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  access_addr
);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_after(input logic [PTR_W-1:0] p,
                                                 input trd_mode_e m);
    case (m)
      TRD_POST_INC, TRD_PRE_INC: return ptr_inc(p);
      TRD_POST_DEC:              return ptr_dec(p);
      default:                   return p;
    endcase
  endfunction

  trd_mode_e        mode_e;
  logic [PTR_W-1:0] wr_merged;
  logic [PTR_W-1:0] ptr_d;

  assign mode_e = trd_mode_e'(mode);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam int LO = b * BYTE_W;
    localparam int LW = (PTR_W - LO < BYTE_W) ? (PTR_W - LO) : BYTE_W;
    assign wr_merged[LO +: LW] = wr_en[b] ? wr_data[LW-1:0] : ptr_q[LO +: LW];
    if (LW < BYTE_W) begin : g_pad
      logic pad_unused;
      assign pad_unused = ^wr_data[BYTE_W-1:LW];
    end
  end

  assign access_addr = (mode_e == TRD_PRE_INC) ? ptr_inc(ptr_q) : ptr_q;

  always_comb begin
    if (step_en)        ptr_d = ptr_after(ptr_q, mode_e);
    else if (wr_accept) ptr_d = wr_merged;
    else                ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/tblptr_access_seq.sv
module tblptr_access_seq #(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [PTR_W-1:0] access_addr,
  output logic             rd_accept,
  output logic             busy_q,
  output logic [PTR_W-1:0] addr_q
);

  assign rd_accept = rd_req & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else begin
      busy_q <= rd_accept;
      if (rd_accept) addr_q <= access_addr;
    end
  end

endmodule

// File: rtl/tblptr_byte_latch.sv
module tblptr_byte_latch #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int SEL_W = $clog2(WORD_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] word,
  output logic [BYTE_W-1:0] latch_q
);

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic [SEL_W-1:0] s);
    return w[int'(s) * BYTE_W +: BYTE_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (capture) latch_q <= pick_byte(word, sel);
  end

endmodule

// File: rtl/tblptr_reader.sv
module tblptr_reader #(
  parameter int PTR_W  = 22,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = (PTR_W + BYTE_W - 1) / BYTE_W,
  localparam int SEL_W = $clog2(WORD_W / BYTE_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic [1:0]              rd_mode,
  input  logic [LANES-1:0]        ptr_wr_en,
  input  logic [BYTE_W-1:0]       ptr_wr_data,
  output logic [LANES*BYTE_W-1:0] ptr_rd,
  output logic                    mem_rd,
  output logic [PTR_W-SEL_W-1:0]  mem_addr,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    busy,
  output logic [BYTE_W-1:0]       tab_latch
);

  logic             rd_accept;
  logic             wr_accept;
  logic             capture_evt;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] access_addr;
  logic [PTR_W-1:0] addr_q;
  logic             busy_q;

  assign wr_accept   = ~busy_q & ~rd_req;
  assign capture_evt = busy_q;

  tblptr_ptr_reg #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ptr_wr_en),
    .wr_data    (ptr_wr_data),
    .wr_accept  (wr_accept),
    .step_en    (rd_accept),
    .mode       (rd_mode),
    .ptr_q      (ptr_q),
    .access_addr(access_addr)
  );

  tblptr_access_seq #(.PTR_W(PTR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .access_addr(access_addr),
    .rd_accept  (rd_accept),
    .busy_q     (busy_q),
    .addr_q     (addr_q)
  );

  tblptr_byte_latch #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture_evt),
    .sel    (addr_q[SEL_W-1:0]),
    .word   (mem_rdata),
    .latch_q(tab_latch)
  );

  assign ptr_rd   = (LANES*BYTE_W)'(ptr_q);
  assign mem_addr = addr_q[PTR_W-1:SEL_W];
  assign mem_rd   = busy_q;
  assign busy     = busy_q;

endmodule

// File: rtl/tblptr_reader_chk.sv
module tblptr_reader_chk #(
  parameter int PTR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [1:0]        rd_mode,
  input logic [23:0]       ptr_rd,
  input logic              mem_rd,
  input logic [PTR_W-2:0]  mem_addr,
  input logic              busy,
  input logic [7:0]        tab_latch
);

  logic [PTR_W-1:0] ptr_now;
  logic [PTR_W-1:0] ptr_plus1;
  logic [PTR_W-1:0] ptr_minus1;
  logic             start;

  assign ptr_now    = ptr_rd[PTR_W-1:0];
  assign ptr_plus1  = ptr_now + PTR_W'(1);
  assign ptr_minus1 = ptr_now - PTR_W'(1);
  assign start      = rd_req && !busy;

  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && mem_rd);                                    // R3
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);                                              // R3
  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_mode == 2'b00) |=> $stable(ptr_now) && mem_addr == $past(ptr_now[PTR_W-1:1])); // R5
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_mode == 2'b01) |=> ptr_now == $past(ptr_plus1) && mem_addr == $past(ptr_now[PTR_W-1:1])); // R6
  AST_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_mode == 2'b10) |=> ptr_now == $past(ptr_minus1) && mem_addr == $past(ptr_now[PTR_W-1:1])); // R6
  AST_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_mode == 2'b11) |=> ptr_now == $past(ptr_plus1) && mem_addr == $past(ptr_plus1[PTR_W-1:1])); // R7
  AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr_now));                                   // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tab_latch));                                // R10

endmodule

bind tblptr_reader tblptr_reader_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_mode  (rd_mode),
  .ptr_rd   (ptr_rd),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .busy     (busy),
  .tab_latch(tab_latch)
);

// File: tb/tblptr_reader_bench.sv
module tblptr_reader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_mode = 2'b00;
  logic [2:0]  ptr_wr_en = 3'b000;
  logic [7:0]  ptr_wr_data = 8'h00;
  logic [23:0] ptr_rd;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        busy;
  logic [7:0]  tab_latch;

  int vectors = 0;
  int misc = 0;
  logic [21:0] model = '0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] word_of(input logic [20:0] wa);
    return {wa[7:0] ^ wa[15:8] ^ 8'h96, wa[7:0] + wa[20:13] + 8'h11};
  endfunction

  function automatic logic [7:0] byte_of(input logic [21:0] ba);
    logic [15:0] w;
    w = word_of(ba[21:1]);
    return ba[0] ? w[15:8] : w[7:0];
  endfunction

  always_comb mem_rdata = word_of(mem_addr);

  tblptr_reader u_tblptr_reader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .ptr_rd(ptr_rd),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .tab_latch(tab_latch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misc++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_ptr(input logic [21:0] p);
    @(negedge clk); ptr_wr_en = 3'b001; ptr_wr_data = p[7:0];
    @(negedge clk); ptr_wr_en = 3'b010; ptr_wr_data = p[15:8];
    @(negedge clk); ptr_wr_en = 3'b100; ptr_wr_data = {2'b11, p[21:16]};
    @(negedge clk); ptr_wr_en = 3'b000;
    model = p;
    chk("R2 pointer load", ptr_rd, {2'b00, p});
  endtask

  task automatic do_read(input logic [1:0] m);
    logic [21:0] acc;
    logic [21:0] nxt;
    string tag;
    case (m)
      2'b00: begin acc = model;      nxt = model;      tag = "R5 hold"; end
      2'b01: begin acc = model;      nxt = model + 1;  tag = "R6 post-inc"; end
      2'b10: begin acc = model;      nxt = model - 1;  tag = "R6 post-dec"; end
      default: begin acc = model + 1; nxt = model + 1; tag = "R7 pre-inc"; end
    endcase
    @(negedge clk); rd_req = 1'b1; rd_mode = m;
    @(posedge clk); #1; rd_req = 1'b0;
    chk("R3 busy high", {busy, mem_rd}, 2'b11);
    chk({tag, " R4 word address"}, mem_addr, acc[21:1]);
    chk({tag, " R8 pointer step"}, ptr_rd, {2'b00, nxt});
    @(posedge clk); #1;
    chk("R3 busy low", {busy, mem_rd}, 2'b00);
    chk({tag, " R4 latched byte"}, tab_latch, byte_of(acc));
    model = nxt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misc++; vectors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
    $finish;
  end

  initial begin
    logic [21:0] starts [12];
    logic [7:0]  held;
    starts = '{22'h000000, 22'h000001, 22'h0000FF, 22'h000100, 22'h00FFFF,
               22'h010000, 22'h1FFFFE, 22'h1FFFFF, 22'h200000, 22'h3FFFFE,
               22'h3FFFFF, 22'h2A5C3B};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", {ptr_rd, busy, mem_rd, tab_latch, mem_addr},
        {24'h0, 1'b0, 1'b0, 8'h00, 21'h0});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, ptr_rd}, {1'b0, 24'h0});

    // R2: upper lane ignores bits 7:6 and pads with zero
    write_ptr(22'h3FFFFF);
    chk("R2 padding bits", ptr_rd[23:22], 2'b00);

    // R5 R6 R7 R8: sweep start points across lanes and wrap edges in every mode
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 4; m++) begin
        write_ptr(starts[i]);
        do_read(2'(m));
      end
    end

    // R8: single set bit walked over every position, every mode
    for (int b = 0; b < 22; b++) begin
      for (int m = 0; m < 4; m++) begin
        write_ptr(22'(1) << b);
        do_read(2'(m));
      end
    end

    // R6: zero-terminated string walk with post-increment
    write_ptr(22'h0001D0);
    for (int n = 0; n < 64; n++) begin
      do_read(2'b01);
      if (tab_latch == 8'h00) break;
    end
    chk("R6 string end address", ptr_rd, 24'h0001DF);

    // R9: write in the accepting cycle, then request and write during busy
    write_ptr(22'h001234);
    @(negedge clk); rd_req = 1'b1; rd_mode = 2'b01; ptr_wr_en = 3'b001; ptr_wr_data = 8'hFF;
    @(posedge clk); #1;
    rd_mode = 2'b11; ptr_wr_en = 3'b010; ptr_wr_data = 8'hAA;
    chk("R9 write with accepted request", ptr_rd, 24'h001235);
    @(posedge clk); #1;
    rd_req = 1'b0; ptr_wr_en = 3'b000;
    chk("R9 request in busy ignored", busy, 1'b0);
    chk("R9 write in busy ignored", ptr_rd, 24'h001235);
    chk("R4 latch from first read", tab_latch, byte_of(22'h001234));
    @(posedge clk); #1;
    chk("R9 no second access", {busy, mem_rd}, 2'b00);

    // R10: latch holds across pointer writes and idle cycles
    held = tab_latch;
    model = 22'h001235;
    write_ptr(22'h155555);
    repeat (3) @(negedge clk);
    chk("R10 latch held", tab_latch, held);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
    $finish;
  end

endmodule